// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped station-management master for Clause 22 PHY access. A host on a single-cycle register bus programs a control register holding the clock divider and a preamble switch. It then writes one packed 32-bit command word to a data register. The command word has the same bit layout as the serial frame. The block shifts it out MSB-first on the management data line, paced by a divided management clock. For read operations it releases the line and collects sixteen bits that the PHY returns.

The host polls a busy flag in the control register. When busy is low after a read, the low half of the data register holds the value returned by the PHY. The divider can be rewritten at any moment, for example to restore it after a power-state change, and the new value takes effect on the next clock phase.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy is 0, `mdio_oe` is 0 and `mdc` is 0. The control register reads 0x0000009A: divider 26 and preamble enabled.
- R2: The control register is at offset 0x00. Its fields are divider in bits 6:0, preamble enable in bit 7 and busy in bit 8; busy is read-only and writes to it have no effect. Bits 31:9 read as 0.
- R3: While a frame runs, `mdc` stays high for divider+1 clocks and low for divider+1 clocks, so its period is 2*(divider+1) clocks.
- R4: The data register is at offset 0x04 with this layout: data in 15:0, turnaround in 17:16, register address in 22:18, PHY address in 27:23, opcode in 29:28 and start bit in 30. Bit 31 reads 0. A write to it while idle stores the word and sets busy on the same clock edge.
- R5: With the preamble enabled, the frame is 32 ones followed by command bits 31..0, MSB first, with bit 31 sent as 0. With the preamble disabled, only the 32 command bits are sent. Each bit is valid at a rising `mdc` edge.
- R6: `mdio_out` changes only when `mdc` falls or when a frame is launched.
- R7: Opcode 2 selects a read. For a read, `mdio_oe` is low for the last 17 bit times: the second turnaround bit and the 16 data bits. `mdio_in` is sampled on each rising `mdc` edge of the data bits, MSB first, and the result is placed in data register bits 15:0 when the frame ends. In every other bit time, and for any other opcode, `mdio_oe` is high.
- R8: Busy clears only at the falling `mdc` edge that ends the last bit. While idle, `mdc` is low and `mdio_oe` is low.
- R9: A data-register write while busy is ignored. The data register read-back value does not change while a frame is in progress.
- R10: A divider written during a frame sets the `mdc` timing from the next half period onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe, one cycle |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_in | input | 1 | Management data sampled from the line |

## Verification
The bench first targets the read turnaround. A master that releases the line one bit early or late would show an oe-low count other than 17, or a shifted returned value such as 0x8001 read back as 0x0002. It then runs frames with the divider at 0 and with a divider rewritten mid-frame. A counter that compares for equality instead of reaching the limit would lose a half period or run away. The bench also writes to the data register during a frame. A design that accepted that write would change the read-back value or restart the shifter, which corrupts the captured bit stream. Finally, it runs frames with the preamble disabled, to expose any logic that always counts 64 bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // control register field positions (host software decodes these)
  localparam int unsigned DIV_W      = 7;
  localparam int unsigned PRE_BIT    = 7;
  localparam int unsigned BUSY_BIT   = 8;
  // register offsets
  localparam logic [7:0]  OFS_CTRL   = 8'h00;
  localparam logic [7:0]  OFS_DATA   = 8'h04;
  // frame geometry
  localparam int unsigned CMD_W      = 32;
  localparam int unsigned PRE_LEN    = 32;
  localparam int unsigned RD_LEN     = 16;
  localparam int unsigned CNT_W      = 7;
  localparam int unsigned OP_LSB     = 28;
  localparam logic [1:0]  OP_READ    = 2'b10;
  localparam logic [1:0]  OP_WRITE   = 2'b01;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  always_comb begin
    tick  = run && (cnt_q >= div);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = tick & ~mdc_q;
  assign fall_tick = tick &  mdc_q;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pre_en,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_in,
  output logic              busy,
  output logic              is_read,
  output logic              done,
  output logic [RD_LEN-1:0] rd_data,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam int unsigned SH_W = PRE_LEN + CMD_W;
  localparam logic [CNT_W-1:0] LEN_PRE  = CNT_W'(SH_W);
  localparam logic [CNT_W-1:0] LEN_BARE = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] REL_AT   = CNT_W'(RD_LEN + 1);
  localparam logic [CNT_W-1:0] CAP_AT   = CNT_W'(RD_LEN);

  logic [SH_W-1:0]   sh_q, sh_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [RD_LEN-1:0] rd_q, rd_d;
  logic              busy_q, busy_d;
  logic              read_q, read_d;
  logic [CMD_W-1:0]  word;

  always_comb begin
    word   = {1'b0, cmd[CMD_W-2:0]};
    sh_d   = sh_q;
    left_d = left_q;
    rd_d   = rd_q;
    busy_d = busy_q;
    read_d = read_q;
    done   = 1'b0;
    if (start && !busy_q) begin
      sh_d   = pre_en ? {{PRE_LEN{1'b1}}, word} : {word, {PRE_LEN{1'b0}}};
      left_d = pre_en ? LEN_PRE : LEN_BARE;
      read_d = (cmd[OP_LSB+:2] == OP_READ);
      busy_d = 1'b1;
      rd_d   = '0;
    end else if (busy_q) begin
      if (rise_tick && read_q && (left_q <= CAP_AT))
        rd_d = {rd_q[RD_LEN-2:0], mdio_in};
      if (fall_tick) begin
        sh_d   = {sh_q[SH_W-2:0], 1'b0};
        left_d = left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      rd_q   <= '0;
      busy_q <= 1'b0;
      read_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      rd_q   <= rd_d;
      busy_q <= busy_d;
      read_q <= read_d;
    end
  end

  assign busy     = busy_q;
  assign is_read  = read_q;
  assign rd_data  = rd_q;
  assign mdio_out = sh_q[SH_W-1];
  assign mdio_oe  = busy_q && !(read_q && (left_q <= REL_AT));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DIV_RST = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  logic [DIV_W-1:0]  div_q, div_d;
  logic              pre_q, pre_d;
  logic [CMD_W-2:0]  data_q, data_d;
  logic              busy_w, rd_frame_w, done_w, start_w;
  logic              rise_w, fall_w;
  logic [RD_LEN-1:0] rd_w;
  logic              sel_ctrl, sel_data;
  logic              unused_wbit;

  assign unused_wbit = bus_wdata[31];
  assign sel_ctrl = (bus_addr == A_CTRL);
  assign sel_data = (bus_addr == A_DATA);
  assign start_w  = bus_wr_en && sel_data && !busy_w;

  always_comb begin
    div_d  = div_q;
    pre_d  = pre_q;
    data_d = data_q;
    if (bus_wr_en && sel_ctrl) begin
      div_d = bus_wdata[DIV_W-1:0];
      pre_d = bus_wdata[PRE_BIT];
    end
    if (start_w)
      data_d = bus_wdata[CMD_W-2:0];
    else if (done_w && rd_frame_w)
      data_d[RD_LEN-1:0] = rd_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(DIV_RST);
      pre_q  <= 1'b1;
      data_q <= '0;
    end else begin
      div_q  <= div_d;
      pre_q  <= pre_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[DIV_W-1:0] = div_q;
      bus_rdata[PRE_BIT]   = pre_q;
      bus_rdata[BUSY_BIT]  = busy_w;
    end else if (sel_data) begin
      bus_rdata = {1'b0, data_q};
    end
  end

  mdio_clkgen u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_w),
    .div       (div_q),
    .mdc       (mdc),
    .rise_tick (rise_w),
    .fall_tick (fall_w)
  );

  mdio_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .pre_en    (pre_q),
    .cmd       (bus_wdata),
    .rise_tick (rise_w),
    .fall_tick (fall_w),
    .mdio_in   (mdio_in),
    .busy      (busy_w),
    .is_read   (rd_frame_w),
    .done      (done_w),
    .rd_data   (rd_w),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              mdc,
  input logic              mdio_out,
  input logic              mdio_oe,
  input logic              busy,
  input logic              is_read,
  input logic [30:0]       data_q
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(8'h04) && !busy) |=> busy); // R4

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_out != $past(mdio_out)) |-> ($fell(mdc) || $rose(busy))); // R6

  AST_RELEASE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |-> is_read); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R8

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_q)); // R9
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .mdc       (mdc),
  .mdio_out  (mdio_out),
  .mdio_oe   (mdio_oe),
  .busy      (busy_w),
  .is_read   (rd_frame_w),
  .data_q    (data_q)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk;
  logic        rst_n;
  logic        bus_wr_en;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // monitor state
  int          mon_cnt;
  int          mon_oelow;
  logic [63:0] mon_bits;
  realtime     t_prev;
  realtime     last_period;
  int          pre_off;
  logic [15:0] phy_word;
  int          mon_f;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge mdc) begin
    mon_bits  <= {mon_bits[62:0], mdio_oe ? mdio_out : 1'b0};
    if (!mdio_oe) mon_oelow <= mon_oelow + 1;
    mon_cnt   <= mon_cnt + 1;
    last_period <= $realtime - t_prev;
    t_prev    <= $realtime;
  end

  // PHY model: returns phy_word during the data bits, pull-up elsewhere
  always_comb begin
    mon_f = mon_cnt - pre_off;
    if (mon_f >= 16 && mon_f < 32) mdio_in = phy_word[31 - mon_f];
    else                           mdio_in = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] pa,
                                         input logic [4:0] ra, input logic [15:0] dat);
    return {1'b0, 1'b1, op, pa, ra, 2'b10, dat};
  endfunction

  function automatic logic [63:0] exp_bits(input logic [31:0] c, input bit pre);
    logic [63:0] e;
    e = pre ? {32'hFFFF_FFFF, 1'b0, c[30:0]} : {32'h0, 1'b0, c[30:0]};
    if (c[29:28] == 2'b10) e[16:0] = '0;
    return e;
  endfunction

  task automatic wait_idle(output bit ok);
    logic [31:0] r;
    ok = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      bus_read(8'h00, r);
      if (!r[8]) begin ok = 1'b1; break; end
    end
  endtask

  // runs one frame; mid_div >= 0 rewrites the divider after two mdc rises
  task automatic run_frame(input logic [31:0] c, input bit pre, input int div,
                           input logic [15:0] pw, input bit intrude, input int mid_div);
    logic [31:0] r;
    logic [31:0] exp_rd;
    bit ok;
    int eff_div;
    bus_write(8'h00, {24'h0, pre, 7'(div)});
    phy_word  = pw;
    pre_off   = pre ? 32 : 0;
    mon_cnt   = 0;
    mon_oelow = 0;
    mon_bits  = '0;
    eff_div   = div;
    bus_write(8'h04, c);
    bus_read(8'h00, r);
    check(r[8] == 1'b1, "R4 busy after launch", r[8], 1);
    if (intrude) begin
      bus_write(8'h04, 32'h5555_5555);
      bus_read(8'h04, r);
      check(r == {1'b0, c[30:0]}, "R9 write while busy ignored", r, {1'b0, c[30:0]});
    end
    if (mid_div >= 0) begin
      @(posedge mdc); @(posedge mdc);
      bus_write(8'h00, {24'h0, pre, 7'(mid_div)});
      eff_div = mid_div;
    end
    wait_idle(ok);
    check(ok, "R8 busy clears", ok, 1);
    #1;
    check(mon_cnt == (pre ? 64 : 32), "R5/R8 rising edge count", mon_cnt, pre ? 64 : 32);
    check(mon_bits == exp_bits(c, pre), "R5 serial bits", mon_bits, exp_bits(c, pre));
    check(mon_oelow == ((c[29:28] == 2'b10) ? 17 : 0), "R7 release length",
          mon_oelow, (c[29:28] == 2'b10) ? 17 : 0);
    check(last_period == realtime'(8 * (eff_div + 1)), (mid_div >= 0) ? "R10 new period" : "R3 mdc period",
          64'(int'(last_period)), 64'(8 * (eff_div + 1)));
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle lines", {mdc, mdio_oe}, 0);
    exp_rd = (c[29:28] == 2'b10) ? {1'b0, c[30:16], pw} : {1'b0, c[30:0]};
    bus_read(8'h04, r);
    check(r == exp_rd, "R7/R4 data readback", r, exp_rd);
  endtask

  initial begin
    #(4ns * 190000);
    if (!ended) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int seed;
    seed = 13;
    void'($urandom(seed));
    bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    mon_cnt = 0; mon_oelow = 0; mon_bits = '0; pre_off = 0; phy_word = '0;
    t_prev = 0; last_period = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset lines", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    bus_read(8'h00, r);
    check(r == 32'h0000_009A, "R1 reset control", r, 32'h9A);

    bus_write(8'h00, 32'hFFFF_F181);
    bus_read(8'h00, r);
    check(r == 32'h0000_0081, "R2 control fields, busy read-only", r, 32'h81);

    // directed: write frame with preamble and an intruding write
    run_frame(mk_cmd(2'b01, 5'h11, 5'h03, 16'hA5C3), 1'b1, 1, 16'h0000, 1'b1, -1);
    // directed: read frame without preamble, divider 0, edge data pattern
    run_frame(mk_cmd(2'b10, 5'h1F, 5'h1F, 16'h0000), 1'b0, 0, 16'h8001, 1'b0, -1);
    // directed: read with preamble, larger divider
    run_frame(mk_cmd(2'b10, 5'h00, 5'h01, 16'hFFFF), 1'b1, 10, 16'h7FFE, 1'b1, -1);
    // directed: divider rewritten mid-frame
    run_frame(mk_cmd(2'b01, 5'h05, 5'h0A, 16'h1234), 1'b1, 5, 16'h0000, 1'b0, 0);

    // random frames
    for (int i = 0; i < 14; i++) begin
      logic [1:0] op;
      op = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      run_frame(mk_cmd(op, 5'($urandom), 5'($urandom), 16'($urandom)),
                1'($urandom), int'($urandom % 4), 16'($urandom), 1'($urandom), -1);
    end

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule